// File: doc/BRIEF.md
# LIN Receive Status Flag Unit

This unit keeps the receive-side status word of a UART-style serial port running in LIN mode. A receiver core sends it single-cycle event strobes and the value of each finished character. These events are a corrupted sync field, a header timeout, an overrun, a break, an idle line, detected noise, a finished character with its sampled stop bit, and a finished identifier byte. The unit turns these events into sticky flags. It adds the LIN rules on top of plain UART flags: the three header faults share one flag, a break never counts as a framing error, and the identifier parity is checked in hardware.

Software sees the flags through an 8-bit status word. It clears them with the usual two-step handshake: first read the status, then read the data. Only the flags that were visible at the status read are cleared. While the receiver is held in sync-field state, the merged header flag cannot be cleared. A single interrupt line collects every enabled flag and is registered.

Top module: `lin_rx_flags`

## Requirements
- R1: After reset, `status_o` is 0xC0, `hdr_det_o` is 0 and `irq_o` is 0. The status bit layout is: bit 7 transmit-empty, bit 6 transmit-complete, bit 5 receive-full, bit 4 idle, bit 3 header error, bit 2 noise, bit 1 framing error, bit 0 parity error.
- R2: A strobe on `ev_sync_bad`, `ev_hdr_timeout` or `ev_overrun` sets status bit 3 on the next clock edge.
- R3: While `sync_lock` is 1, status bit 3 cannot be cleared by the read handshake. Once `sync_lock` returns to 0, a new handshake clears it.
- R4: Status bits 0 to 4 and `hdr_det_o` clear only when a `rd_data` strobe follows an earlier `rd_stat` strobe. The handshake clears only the flags that were set at the `rd_stat` cycle. A flag that sets between the two reads stays set. A `rd_data` strobe with no status read armed clears nothing.
- R5: On `ev_char` with `char_stop` = 0, bit 1 sets as follows. In slave mode (`slave_mode` = 1) it sets only if at least one bit of `char_data` is 1. In master mode it sets whenever `char_stop` is 0.
- R6: A character with `char_data` all 0 and `char_stop` = 0 never sets bit 1 in slave mode. An `ev_break` strobe sets `hdr_det_o` when `brk_mode` = 0 and has no effect when `brk_mode` = 1.
- R7: On `ev_id`, let id = `id_byte`[5:0]. Parity bit P0 = id0^id1^id2^id4 is compared with `id_byte`[6]. Parity bit P1 = NOT(id1^id3^id4^id5) is compared with `id_byte`[7]. If either differs and `par_en` = 1, bit 0 sets. If `par_en` = 0, bit 0 does not set.
- R8: `irq_o` equals, one clock later, the value of (`rx_ie` AND (bit 5 OR bit 3 OR `hdr_det_o`)) OR (`par_ie` AND bit 0).
- R9: In slave mode, `ev_noise` has no effect and bit 2 reads 0. In master mode, `ev_noise` sets bit 2.
- R10: `ev_char` sets bit 5, and the read handshake clears it. Bits 7 and 6 show `tx_empty_i` and `tx_done_i` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_char | input | 1 | Character finished strobe |
| char_data | input | 8 | Data bits of the finished character |
| char_stop | input | 1 | Sampled stop bit of the finished character |
| ev_id | input | 1 | Identifier byte finished strobe |
| id_byte | input | 8 | Received identifier byte with its parity bits |
| ev_sync_bad | input | 1 | Sync field corrupted strobe |
| ev_hdr_timeout | input | 1 | Header timeout strobe |
| ev_overrun | input | 1 | Overrun strobe |
| ev_break | input | 1 | Break detected strobe |
| ev_noise | input | 1 | Noise detected strobe |
| ev_idle | input | 1 | Idle line strobe |
| sync_lock | input | 1 | Receiver held in sync-field state |
| slave_mode | input | 1 | 1 = slave node, 0 = master node |
| brk_mode | input | 1 | 0 = report a break on `hdr_det_o` |
| par_en | input | 1 | Identifier parity check enable |
| rx_ie | input | 1 | Receive and header interrupt enable |
| par_ie | input | 1 | Parity interrupt enable |
| tx_empty_i | input | 1 | Transmit-empty level from the transmitter |
| tx_done_i | input | 1 | Transmit-complete level from the transmitter |
| rd_stat | input | 1 | Status register read strobe |
| rd_data | input | 1 | Data register read strobe |
| status_o | output | 8 | Status word |
| hdr_det_o | output | 1 | Header (break) detected flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A wrong clear-pending latch or a wrong snapshot shows up on `status_o` at the first edge after a data read. Depending on the fault, a flag either survives the handshake or disappears even though it was set between the two reads. A wrong sync-lock gate shows up the same way, on bit 3. A wrong framing or parity qualifier changes `status_o` one edge after the character or identifier strobe. A wrong interrupt term appears on `irq_o` exactly one edge after the flag that should drive it.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;
   localparam int FLAG_N  = 7;
   localparam int FI_PE   = 0;
   localparam int FI_FE   = 1;
   localparam int FI_NF   = 2;
   localparam int FI_HE   = 3;
   localparam int FI_IDLE = 4;
   localparam int FI_RDRF = 5;
   localparam int FI_BRK  = 6;
   typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/lin_id_parity.sv
module lin_id_parity #(
   parameter int ID_W   = 6,
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] id_byte,
   output logic              mismatch
);
   logic [ID_W-1:0] id;
   logic            p0, p1;

   assign id = id_byte[ID_W-1:0];
   assign p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
   assign p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
   assign mismatch = (p0 != id_byte[ID_W]) | (p1 != id_byte[ID_W+1]);
endmodule

// File: rtl/lin_char_qual.sv
module lin_char_qual #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] char_data,
   input  logic              char_stop,
   input  logic              slave_mode,
   output logic              fe_hit
);
   logic all_dom;

   assign all_dom = ~|char_data;
   // slave: stop dominant and some other bit recessive; master: any bad stop
   assign fe_hit  = ~char_stop & (slave_mode ? ~all_dom : 1'b1);
endmodule

// File: rtl/lin_flag_cell.sv
module lin_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/lin_clr_seq.sv
module lin_clr_seq #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_stat,
   input  logic         rd_data,
   input  logic [N-1:0] flags,
   input  logic [N-1:0] clr_ok,
   output logic [N-1:0] clr_vec
);
   logic         pend;
   logic [N-1:0] snap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         snap <= '0;
      end else if (rd_stat) begin
         pend <= 1'b1;
         snap <= flags;
      end else if (rd_data) begin
         pend <= 1'b0;
         snap <= '0;
      end
   end

   assign clr_vec = (rd_data && pend) ? (snap & clr_ok) : '0;
endmodule

// File: rtl/lin_irq_gen.sv
module lin_irq_gen #(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic irq
);
   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= req;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq = req;
      end
   endgenerate
endmodule

// File: rtl/lin_rx_flags.sv
module lin_rx_flags
   import lin_rx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int ID_W    = 6,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_char,
   input  logic [DATA_W-1:0] char_data,
   input  logic              char_stop,
   input  logic              ev_id,
   input  logic [DATA_W-1:0] id_byte,
   input  logic              ev_sync_bad,
   input  logic              ev_hdr_timeout,
   input  logic              ev_overrun,
   input  logic              ev_break,
   input  logic              ev_noise,
   input  logic              ev_idle,
   input  logic              sync_lock,
   input  logic              slave_mode,
   input  logic              brk_mode,
   input  logic              par_en,
   input  logic              rx_ie,
   input  logic              par_ie,
   input  logic              tx_empty_i,
   input  logic              tx_done_i,
   input  logic              rd_stat,
   input  logic              rd_data,
   output logic [7:0]        status_o,
   output logic              hdr_det_o,
   output logic              irq_o
);
   localparam int STAT_W = 8;

   initial begin
      if (DATA_W != ID_W + 2) $error("lin_rx_flags: DATA_W must equal ID_W+2");
      if (ID_W != 6)          $error("lin_rx_flags: ID_W must be 6");
   end

   flag_vec_t  set_v, clr_v, clr_ok, flag_q;
   logic       par_bad, fe_hit;
   logic [1:0] tx_q;
   logic       irq_req;

   lin_id_parity #(.ID_W(ID_W), .DATA_W(DATA_W)) u_par (
      .id_byte (id_byte),
      .mismatch(par_bad)
   );

   lin_char_qual #(.DATA_W(DATA_W)) u_qual (
      .char_data (char_data),
      .char_stop (char_stop),
      .slave_mode(slave_mode),
      .fe_hit    (fe_hit)
   );

   always_comb begin
      set_v          = '0;
      set_v[FI_PE]   = ev_id & par_en & par_bad;
      set_v[FI_FE]   = ev_char & fe_hit;
      set_v[FI_NF]   = ev_noise & ~slave_mode;
      set_v[FI_HE]   = ev_sync_bad | ev_hdr_timeout | ev_overrun;
      set_v[FI_IDLE] = ev_idle;
      set_v[FI_RDRF] = ev_char;
      set_v[FI_BRK]  = ev_break & ~brk_mode;
      clr_ok         = '1;
      clr_ok[FI_HE]  = ~sync_lock;
   end

   lin_clr_seq #(.N(FLAG_N)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_stat(rd_stat),
      .rd_data(rd_data),
      .flags  (flag_q),
      .clr_ok (clr_ok),
      .clr_vec(clr_v)
   );

   genvar gi;
   generate
      for (gi = 0; gi < FLAG_N; gi++) begin : g_flag
         lin_flag_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (set_v[gi]),
            .clr  (clr_v[gi]),
            .q    (flag_q[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_q <= 2'b11;
      else        tx_q <= {tx_empty_i, tx_done_i};
   end

   logic [STAT_W-1:0] stat_c;
   always_comb begin
      stat_c    = '0;
      stat_c[7] = tx_q[1];
      stat_c[6] = tx_q[0];
      stat_c[5] = flag_q[FI_RDRF];
      stat_c[4] = flag_q[FI_IDLE];
      stat_c[3] = flag_q[FI_HE];
      stat_c[2] = flag_q[FI_NF] & ~slave_mode;
      stat_c[1] = flag_q[FI_FE];
      stat_c[0] = flag_q[FI_PE];
   end
   assign status_o  = stat_c;
   assign hdr_det_o = flag_q[FI_BRK];

   assign irq_req = (rx_ie & (flag_q[FI_RDRF] | flag_q[FI_HE] | flag_q[FI_BRK]))
                  | (par_ie & flag_q[FI_PE]);

   lin_irq_gen #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (irq_req),
      .irq  (irq_o)
   );
endmodule

// File: rtl/lin_rx_flags_chk.sv
module lin_rx_flags_chk #(
   parameter bit IRQ_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       ev_sync_bad,
   input logic       ev_hdr_timeout,
   input logic       ev_overrun,
   input logic       sync_lock,
   input logic       rd_data,
   input logic       ev_id,
   input logic       par_en,
   input logic       ev_char,
   input logic [7:0] char_data,
   input logic       slave_mode,
   input logic       rx_ie,
   input logic       par_ie,
   input logic [7:0] status_o,
   input logic       irq_o
);
   AST_HE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_sync_bad || ev_hdr_timeout || ev_overrun) |=> status_o[3]); // R2
   AST_HE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_lock && status_o[3]) |=> status_o[3]); // R3
   AST_FE_CLR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[1]) |-> $past(rd_data)); // R4
   AST_BRK_NO_FE: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode && ev_char && char_data == 8'h00 && !status_o[1]) |=> !status_o[1]); // R6
   AST_PE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_id && !par_en && !status_o[0]) |=> !status_o[0]); // R7
   generate
      if (IRQ_REG) begin : g_irq_chk
         AST_IRQ_HDR: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_ie && status_o[3]) |=> irq_o); // R8
         AST_IRQ_PAR: assert property (@(posedge clk) disable iff (!rst_n)
            (par_ie && status_o[0]) |=> irq_o); // R8
      end
   endgenerate
endmodule

bind lin_rx_flags lin_rx_flags_chk #(.IRQ_REG(IRQ_REG)) u_chk (.*);

// File: tb/lin_rx_flags_tb.sv
module lin_rx_flags_tb;
   logic clk = 1'b0;
   logic rst_n;
   logic ev_char, char_stop, ev_id, ev_sync_bad, ev_hdr_timeout, ev_overrun;
   logic ev_break, ev_noise, ev_idle, sync_lock, slave_mode, brk_mode;
   logic par_en, rx_ie, par_ie, tx_empty_i, tx_done_i, rd_stat, rd_data;
   logic [7:0] char_data, id_byte, status_o;
   logic hdr_det_o, irq_o;
   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lin_rx_flags u_dut (.*);

   typedef struct packed {
      logic       is_id;
      logic       slave;
      logic       pen;
      logic [7:0] data;
      logic       stop;
      logic [7:0] exp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b1, 1'b0, 8'h55, 1'b1, 8'hE0},  // R10 clean char
      '{1'b0, 1'b1, 1'b0, 8'h55, 1'b0, 8'hE2},  // R5 slave bad stop
      '{1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'hE0},  // R6 break char, slave
      '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'hE2},  // R5 master any bad stop
      '{1'b0, 1'b1, 1'b0, 8'h80, 1'b0, 8'hE2},  // R5 one recessive bit
      '{1'b1, 1'b1, 1'b1, 8'h80, 1'b0, 8'hC0},  // R7 good id 0x00
      '{1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 8'hC1},  // R7 bad P1
      '{1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'hC0},  // R7 check disabled
      '{1'b1, 1'b1, 1'b1, 8'h3C, 1'b0, 8'hC0},  // R7 good id 0x3C
      '{1'b1, 1'b1, 1'b1, 8'h7C, 1'b0, 8'hC1},  // R7 bad P0
      '{1'b1, 1'b1, 1'b1, 8'h42, 1'b0, 8'hC0}   // R7 good id 0x02
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic clr_seq();
      step(); rd_stat = 1'b1;
      step(); rd_stat = 1'b0; rd_data = 1'b1;
      step(); rd_data = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      {ev_char, char_stop, ev_id, ev_sync_bad, ev_hdr_timeout, ev_overrun} = '0;
      {ev_break, ev_noise, ev_idle, sync_lock, brk_mode} = '0;
      {par_en, rx_ie, par_ie, rd_stat, rd_data} = '0;
      slave_mode = 1'b1; tx_empty_i = 1'b1; tx_done_i = 1'b1;
      char_data = '0; id_byte = '0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk("R1 status", status_o, 8'hC0);
      chk("R1 hdr_det", {7'd0, hdr_det_o}, 8'h00);
      chk("R1 irq", {7'd0, irq_o}, 8'h00);

      foreach (VEC[i]) begin
         slave_mode = VEC[i].slave;
         par_en     = VEC[i].pen;
         if (VEC[i].is_id) begin
            id_byte = VEC[i].data; ev_id = 1'b1;
         end else begin
            char_data = VEC[i].data; char_stop = VEC[i].stop; ev_char = 1'b1;
         end
         step();
         ev_id = 1'b0; ev_char = 1'b0;
         step();
         chk("R5/R6/R7/R10 vector", status_o, VEC[i].exp);
         clr_seq();
         chk("R4/R10 vector clear", status_o, 8'hC0);
      end
      slave_mode = 1'b1; par_en = 1'b0;

      // R2 each header fault
      for (int k = 0; k < 3; k++) begin
         step();
         ev_sync_bad = (k == 0); ev_hdr_timeout = (k == 1); ev_overrun = (k == 2);
         step();
         {ev_sync_bad, ev_hdr_timeout, ev_overrun} = '0;
         step();
         chk("R2 header fault", status_o, 8'hC8);
         clr_seq();
         chk("R2 header clear", status_o, 8'hC0);
      end

      // R8 registered interrupt from header flag
      rx_ie = 1'b1;
      ev_sync_bad = 1'b1; step(); ev_sync_bad = 1'b0;
      chk("R8 flag first", status_o, 8'hC8);
      chk("R8 irq not yet", {7'd0, irq_o}, 8'h00);
      step();
      chk("R8 irq raised", {7'd0, irq_o}, 8'h01);
      clr_seq();
      step();
      chk("R8 irq dropped", {7'd0, irq_o}, 8'h00);
      rx_ie = 1'b0;

      // R3 sync lock blocks clear
      sync_lock = 1'b1;
      ev_overrun = 1'b1; step(); ev_overrun = 1'b0;
      clr_seq();
      chk("R3 locked keeps flag", status_o, 8'hC8);
      sync_lock = 1'b0;
      clr_seq();
      chk("R3 unlocked clears", status_o, 8'hC0);

      // R4 data read alone, and a flag set between reads
      char_data = 8'h55; char_stop = 1'b0; ev_char = 1'b1; step(); ev_char = 1'b0;
      rd_data = 1'b1; step(); rd_data = 1'b0; step();
      chk("R4 data read alone", status_o, 8'hE2);
      rd_stat = 1'b1; step(); rd_stat = 1'b0;
      ev_sync_bad = 1'b1; step(); ev_sync_bad = 1'b0;
      rd_data = 1'b1; step(); rd_data = 1'b0;
      chk("R4 late flag kept", status_o, 8'hC8);
      clr_seq();
      chk("R4 second handshake", status_o, 8'hC0);

      // R6 break reporting
      brk_mode = 1'b0; ev_break = 1'b1; step(); ev_break = 1'b0;
      chk("R6 break flag", {7'd0, hdr_det_o}, 8'h01);
      clr_seq();
      chk("R6 break flag clear", {7'd0, hdr_det_o}, 8'h00);
      brk_mode = 1'b1; ev_break = 1'b1; step(); ev_break = 1'b0; step();
      chk("R6 break ignored", {7'd0, hdr_det_o}, 8'h00);
      brk_mode = 1'b0;

      // R9 noise
      slave_mode = 1'b1; ev_noise = 1'b1; step(); ev_noise = 1'b0; step();
      chk("R9 slave noise", status_o, 8'hC0);
      slave_mode = 1'b0; ev_noise = 1'b1; step(); ev_noise = 1'b0; step();
      chk("R9 master noise", status_o, 8'hC4);
      clr_seq();
      slave_mode = 1'b1;

      // R7/R8 parity interrupt gating
      par_en = 1'b1; par_ie = 1'b1; id_byte = 8'h00;
      ev_id = 1'b1; step(); ev_id = 1'b0;
      chk("R7 parity flag", status_o, 8'hC1);
      step();
      chk("R8 parity irq", {7'd0, irq_o}, 8'h01);
      clr_seq();
      par_ie = 1'b0;
      ev_id = 1'b1; step(); ev_id = 1'b0; step(); step();
      chk("R8 parity irq masked", {7'd0, irq_o}, 8'h00);
      clr_seq();
      par_en = 1'b0;

      // R10 transmit bits follow inputs
      tx_done_i = 1'b0; step();
      chk("R10 tx done low", status_o, 8'h80);
      tx_done_i = 1'b1; step();
      chk("R10 tx done high", status_o, 8'hC0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule